// File: doc/BRIEF.md
# Width-Switchable Add-With-Carry Unit

This block is the binary add-with-carry stage of an accumulator processor whose accumulator can work at 8 or 16 bits. A mode input picks the width for each operation. The block takes the current accumulator, an operand and the current status byte, and produces the new accumulator and an updated status byte. The status byte holds carry, zero, overflow and negative flags at fixed bit positions. The carry-in is taken from the incoming status byte.

The adder is built from byte-wide lanes joined by a carry chain. In narrow mode only the lowest lane forms the result, and the flags are taken at that lane's boundary. The upper accumulator byte passes through unchanged. In wide mode every lane takes part and the flags come from the top lane. Results are registered: they appear on the clock edge after an input strobe, together with a one-cycle valid pulse, and they hold until the next strobe.

Top module: `wadd_unit`

## Requirements
- R1: With `narrow`=1, acc_out[7:0] is the low 8 bits of acc_in[7:0] + opnd_in[7:0] + carry-in, and acc_out[15:8] equals acc_in[15:8].
- R2: With `narrow`=0, acc_out is the low 16 bits of acc_in + opnd_in + carry-in. The carry-in is stat_in bit 0.
- R3: The carry flag (stat_out bit 0) is set when the unsigned sum exceeds 0xFF in narrow mode, or 0xFFFF in wide mode.
- R4: The overflow flag (stat_out bit 6) is set exactly when both addends have the same sign bit and the result's sign bit differs from it. The sign bit is bit 7 in narrow mode and bit 15 in wide mode.
- R5: The zero flag (stat_out bit 1) is set when the result is zero. In narrow mode only the 8-bit result counts.
- R6: The negative flag (stat_out bit 7) equals the result's sign bit, which is bit 7 in narrow mode and bit 15 in wide mode.
- R7: stat_out bits 2 to 5 are copied from stat_in.
- R8: acc_out and stat_out update on the rising edge after a cycle with in_valid=1, and out_valid is high for exactly that one cycle.
- R9: While in_valid is low, acc_out and stat_out keep their values, whatever the other inputs do.
- R10: A synchronous active-high reset clears out_valid, acc_out and stat_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: add the current inputs |
| narrow | input | 1 | 1 selects 8-bit mode, 0 selects 16-bit mode |
| acc_in | input | 16 | Current accumulator |
| opnd_in | input | 16 | Operand to add |
| stat_in | input | 8 | Current status byte; bit 0 is the carry-in |
| out_valid | output | 1 | One-cycle pulse when a new result is presented |
| acc_out | output | 16 | New accumulator |
| stat_out | output | 8 | New status byte (C bit 0, Z bit 1, V bit 6, N bit 7) |

## Verification
The assertions check the following on every strobe:
- the timing of the valid pulse;
- that results hold between strobes;
- that the upper byte is kept in narrow mode;
- that status bits 2 to 5 pass through;
- that the zero and negative flags match the value actually written to the accumulator;
- that overflow never appears when the addends' signs differ.

Only the bench's directed cases show the arithmetic itself. These cases cover wrap-around carry in both widths, signed overflow at bit 7 and at bit 15, and a narrow-mode zero result while the full accumulator stays nonzero. They also cover a carry-in that turns a sum into an exact wrap to zero.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  localparam int STAT_W = 8;
  localparam int C_BIT  = 0;
  localparam int Z_BIT  = 1;
  localparam int V_BIT  = 6;
  localparam int N_BIT  = 7;
  localparam logic [STAT_W-1:0] FLAG_MASK =
    (8'(1) << C_BIT) | (8'(1) << Z_BIT) | (8'(1) << V_BIT) | (8'(1) << N_BIT);

  typedef struct packed {
    logic c;
    logic z;
    logic v;
    logic n;
  } flags_t;
endpackage

// File: rtl/wadd_lane.sv
// One byte-wide slice of the adder: sum, carry out and signed overflow.
module wadd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum   = total[W-1:0];
    cout  = total[W];
    ovf   = (a[W-1] == b[W-1]) && (total[W-1] != a[W-1]);
  end
endmodule

// File: rtl/wadd_flags.sv
// Picks the lane that marks the active width and derives the four flags.
module wadd_flags
  import wadd_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                         narrow,
  input  logic [LANES-1:0][LANE_W-1:0] lane_sum,
  input  logic [LANES-1:0]             lane_cout,
  input  logic [LANES-1:0]             lane_ovf,
  output flags_t                       flags
);
  localparam int TOP = LANES - 1;

  always_comb begin
    if (narrow) begin
      flags.c = lane_cout[0];
      flags.v = lane_ovf[0];
      flags.n = lane_sum[0][LANE_W-1];
      flags.z = (lane_sum[0] == '0);
    end else begin
      flags.c = lane_cout[TOP];
      flags.v = lane_ovf[TOP];
      flags.n = lane_sum[TOP][LANE_W-1];
      flags.z = (lane_sum == '0);
    end
  end
endmodule

// File: rtl/wadd_unit.sv
module wadd_unit
  import wadd_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              narrow,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [STAT_W-1:0] stat_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] acc_out,
  output logic [STAT_W-1:0] stat_out
);
  logic [LANES-1:0][LANE_W-1:0] lane_sum;
  logic [LANES-1:0]             lane_cout;
  logic [LANES-1:0]             lane_ovf;
  logic [LANES:0]               chain;
  flags_t                       flags;
  logic [DATA_W-1:0]            acc_nxt;
  logic [STAT_W-1:0]            stat_nxt;

  assign chain[0] = stat_in[C_BIT];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wadd_lane #(.W(LANE_W)) u_lane (
      .a    (acc_in[i*LANE_W +: LANE_W]),
      .b    (opnd_in[i*LANE_W +: LANE_W]),
      .cin  (chain[i]),
      .sum  (lane_sum[i]),
      .cout (lane_cout[i]),
      .ovf  (lane_ovf[i])
    );
    assign chain[i+1] = lane_cout[i];
  end

  wadd_flags #(.LANE_W(LANE_W), .LANES(LANES)) u_flags (
    .narrow    (narrow),
    .lane_sum  (lane_sum),
    .lane_cout (lane_cout),
    .lane_ovf  (lane_ovf),
    .flags     (flags)
  );

  always_comb begin
    if (narrow) acc_nxt = {acc_in[DATA_W-1:LANE_W], lane_sum[0]};
    else        acc_nxt = lane_sum;
    stat_nxt        = stat_in;
    stat_nxt[C_BIT] = flags.c;
    stat_nxt[Z_BIT] = flags.z;
    stat_nxt[V_BIT] = flags.v;
    stat_nxt[N_BIT] = flags.n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      stat_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out  <= acc_nxt;
        stat_out <= stat_nxt;
      end
    end
  end
endmodule

// File: rtl/wadd_unit_chk.sv
module wadd_unit_chk
  import wadd_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              narrow,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] opnd_in,
  input logic [STAT_W-1:0] stat_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] acc_out,
  input logic [STAT_W-1:0] stat_out
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc_out) && $stable(stat_out))); // R9
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow) |=> (acc_out[DATA_W-1:LANE_W] == $past(acc_in[DATA_W-1:LANE_W]))); // R1
  AST_PASS_BITS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((stat_out & ~FLAG_MASK) == ($past(stat_in) & ~FLAG_MASK))); // R7
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (stat_out[Z_BIT] == ($past(narrow) ? (acc_out[LANE_W-1:0] == '0)
                                                    : (acc_out == '0)))); // R5
  AST_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_in == '0 && opnd_in == '0 && !stat_in[C_BIT]) |=>
      (stat_out[Z_BIT] && !stat_out[C_BIT])); // R5
  AST_NEG_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (stat_out[N_BIT] == ($past(narrow) ? acc_out[LANE_W-1]
                                                    : acc_out[DATA_W-1]))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow && (acc_in[LANE_W-1] != opnd_in[LANE_W-1])) |=> !stat_out[V_BIT]); // R4
  AST_NO_OVERFLOW_WIDE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !narrow && (acc_in[DATA_W-1] != opnd_in[DATA_W-1])) |=> !stat_out[V_BIT]); // R4
endmodule

bind wadd_unit wadd_unit_chk #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .narrow    (narrow),
  .acc_in    (acc_in),
  .opnd_in   (opnd_in),
  .stat_in   (stat_in),
  .out_valid (out_valid),
  .acc_out   (acc_out),
  .stat_out  (stat_out)
);

// File: tb/wadd_unit_test.sv
module wadd_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        narrow;
  logic [15:0] acc_in;
  logic [15:0] opnd_in;
  logic [7:0]  stat_in;
  logic        out_valid;
  logic [15:0] acc_out;
  logic [7:0]  stat_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wadd_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .narrow(narrow),
    .acc_in(acc_in), .opnd_in(opnd_in), .stat_in(stat_in),
    .out_valid(out_valid), .acc_out(acc_out), .stat_out(stat_out)
  );

  // Reference from the requirements: {acc[15:0], stat[7:0]}
  function automatic logic [23:0] expect_of(input logic n, input logic [15:0] a,
                                            input logic [15:0] b, input logic [7:0] s);
    logic [16:0] t;
    logic [15:0] r;
    logic c, z, v, ng;
    logic cin = s[0];
    if (n) begin
      t  = {9'd0, a[7:0]} + {9'd0, b[7:0]} + {16'd0, cin};
      r  = {a[15:8], t[7:0]};
      c  = t[8];
      z  = (t[7:0] == 8'd0);
      ng = t[7];
      v  = (a[7] == b[7]) && (t[7] != a[7]);
    end else begin
      t  = {1'b0, a} + {1'b0, b} + {16'd0, cin};
      r  = t[15:0];
      c  = t[16];
      z  = (t[15:0] == 16'd0);
      ng = t[15];
      v  = (a[15] == b[15]) && (t[15] != a[15]);
    end
    return {r, ng, v, s[5:2], z, c};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive one strobe, sample the result half a cycle after the capturing edge.
  task automatic apply(input logic n, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] s, input string req);
    logic [23:0] e;
    e = expect_of(n, a, b, s);
    @(negedge clk);
    narrow = n; acc_in = a; opnd_in = b; stat_in = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " acc"}, {16'd0, acc_out}, {16'd0, e[23:8]});
    check({req, " stat"}, {24'd0, stat_out}, {24'd0, e[7:0]});
  endtask

  task automatic t_reset;
    check("R10 valid", {31'd0, out_valid}, 32'd0);
    check("R10 acc", {16'd0, acc_out}, 32'd0);
    check("R10 stat", {24'd0, stat_out}, 32'd0);
  endtask

  task automatic t_wide;
    apply(1'b0, 16'h1234, 16'h1111, 8'h00, "R2 plain");
    apply(1'b0, 16'hFFFF, 16'h0001, 8'h00, "R3 R5 wide wrap");
    check("R3 wide carry", {24'd0, stat_out}, 32'h03);
    apply(1'b0, 16'h7FFF, 16'h0000, 8'h01, "R4 R6 wide ovf");
    check("R4 wide ovf bits", {24'd0, stat_out}, 32'hC0);
    apply(1'b0, 16'h8000, 16'h8000, 8'h00, "R4 wide neg ovf");
  endtask

  task automatic t_narrow;
    apply(1'b1, 16'hAB7F, 16'hCD01, 8'h00, "R1 R4 narrow ovf");
    check("R1 upper kept", {16'd0, acc_out}, 32'hAB80);
    apply(1'b1, 16'h55FF, 16'h0001, 8'h00, "R5 narrow zero");
    check("R5 narrow zero bits", {24'd0, stat_out}, 32'h03);
    apply(1'b1, 16'h1200, 16'h00FF, 8'h01, "R3 narrow carry-in wrap");
    apply(1'b1, 16'h00F0, 16'hFF0F, 8'h00, "R6 narrow neg");
  endtask

  task automatic t_pass;
    apply(1'b0, 16'h0001, 16'h0001, 8'h3C, "R7 pass set");
    check("R7 bits", {24'd0, stat_out}, 32'h3C);
    apply(1'b1, 16'h0001, 16'h0001, 8'hC3, "R7 pass clear");
  endtask

  task automatic t_hold;
    logic [15:0] a0;
    logic [7:0]  s0;
    apply(1'b0, 16'h4321, 16'h0101, 8'h00, "R9 setup");
    a0 = acc_out; s0 = stat_out;
    @(negedge clk);
    narrow = 1'b1; acc_in = 16'hFFFF; opnd_in = 16'hFFFF; stat_in = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check("R8 pulse ended", {31'd0, out_valid}, 32'd0);
    check("R9 acc held", {16'd0, acc_out}, {16'd0, a0});
    check("R9 stat held", {24'd0, stat_out}, {24'd0, s0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; narrow = 1'b0;
    acc_in = '0; opnd_in = '0; stat_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wide();
    t_narrow();
    t_pass();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule